// File: doc/BRIEF.md
# Code-Array Programming Sequencer with Lock Bits

This block is the parallel programming-mode controller for a small on-chip code array. An external programmer presents an address, a data byte and an operation code. It then drives a low-active program strobe. The block runs self-timed byte writes, chip erase, verify reads and signature reads. It also keeps three lock bits, which close off, one stage at a time, further programming, read-back of the array and fetching from external memory.

A byte write starts on one falling edge of the strobe and then times itself. While it runs, the programmer can watch its progress in two ways. A read of the byte being written shows bit 7 inverted until the write is done. The ready line also stays low for the whole write. A chip erase needs the strobe held low for a fixed number of clock cycles, and it returns the array and the lock bits to the blank state. Durations are given as clock counts.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset every array location reads 8'hFF, ready_o is high and no lock bit is set.
- R2: With op_i=3'd1 and prog_en_i high, a sampled falling edge of prog_n_i makes ready_o low from the next cycle for WRITE_CYCLES cycles. After that the addressed byte holds its old value bitwise ANDed with data_i, so a write can only clear bits.
- R3: While a byte write is in progress, a read (op_i=3'd2, sig_sel_n_i not 2'b00) of the address being written returns the target byte with bit 7 inverted. Once ready_o is high again, the same read returns the true byte.
- R4: With op_i=3'd3 and prog_en_i high, holding prog_n_i low for ERASE_CYCLES sampled edges sets every byte to 8'hFF and clears all three lock bits, and ready_o is low while the strobe is held. Releasing the strobe earlier leaves the array unchanged.
- R5: A strobe edge is ignored when prog_en_i is low or while an operation is in progress. Ready_o shows no new busy period and no byte changes.
- R6: A read with sig_sel_n_i=2'b00 returns the signature: address 6'h30 gives 8'h1E, 6'h31 gives 8'h51, 6'h32 gives 8'hFF when HV_PART=1 (8'h05 otherwise), and any other address gives 8'h00. Any other sig_sel_n_i value reads the array.
- R7: Op codes 3'd4, 3'd5 and 3'd6 set lock bits 1, 2 and 3 through a self-timed write of the same length as a byte write. With lock bit 1 set, byte writes are refused: ready_o stays high and the byte is unchanged.
- R8: With lock bits 1 and 2 both set, array reads return 8'h00 while signature reads still work. Lock bit 2 alone does not block reads.
- R9: With all three lock bits set, ext_fetch_o is low.
- R10: ext_fetch_o is the inverse of ea_n_i while lock bit 1 is clear. While lock bit 1 is set, it is the inverse of the ea_n_i value captured during the last cycle with run_rst_i high (reset value: internal).
- R11: rdata_o is registered and appears one cycle after the read is presented. It is 8'h00 whenever op_i is not 3'd2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, returns the array to blank |
| op_i | input | 3 | Operation: 0 none, 1 byte write, 2 read, 3 erase, 4/5/6 lock bit 1/2/3 |
| addr_i | input | ARR_AW | Byte address |
| data_i | input | 8 | Write data |
| sig_sel_n_i | input | 2 | Both low selects signature reads |
| prog_en_i | input | 1 | Program-enable level |
| prog_n_i | input | 1 | Low-active program strobe |
| run_rst_i | input | 1 | Device reset level that captures ea_n_i |
| ea_n_i | input | 1 | External-access strap, low requests external fetch |
| rdata_o | output | 8 | Read, verify, polling and signature data |
| ready_o | output | 1 | High when idle, low while busy |
| ext_fetch_o | output | 1 | External code fetch permitted |

## Verification
A wrong busy count shows up on ready_o, either one edge early or one edge late compared with the exact cycle WRITE_CYCLES after the strobe. A wrong polling or captured target shows up on the first read issued during the write. A corrupted store or AND merge shows up on the next read of that address, which is one cycle after the read is presented. Wrong lock state is seen only through its effects: a refused write, 8'h00 on a read, or ext_fetch_o. Each of these is visible in the cycle after the lock write completes.

// File: rtl/flash_seq_pkg.sv
// Shared operation codes, sequencer states and signature lookup.
package flash_seq_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_BYTE  = 3'd1,
        OP_READ  = 3'd2,
        OP_ERASE = 3'd3,
        OP_LK1   = 3'd4,
        OP_LK2   = 3'd5,
        OP_LK3   = 3'd6,
        OP_RSV   = 3'd7
    } fs_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_BUSY,
        ST_ER_HOLD,
        ST_ER_WAIT
    } fs_state_e;

    // Signature byte for a zero-extended address; hv selects the high-voltage code.
    function automatic logic [BYTE_W-1:0] sig_byte(input logic [31:0] a, input logic hv);
        case (a)
            32'h30:  sig_byte = 8'h1E;
            32'h31:  sig_byte = 8'h51;
            32'h32:  sig_byte = hv ? 8'hFF : 8'h05;
            default: sig_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/fsp_code_array.sv
// Code array model: 2**AW bytes, blank value all ones.
// Assumes that at most one of wr_en_i and erase_i is set in a cycle (erase wins).
module fsp_code_array
    import flash_seq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              erase_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic [BYTE_W-1:0] wr_slot_o
);
    localparam int DEPTH = 1 << AW;

    logic [BYTE_W-1:0] mem [DEPTH];

    // Store: reset and erase fill with ones, a commit replaces one byte.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_i) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem[rd_addr_i];
    assign wr_slot_o = mem[wr_addr_i];

    // R2
    only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !erase_i) |=> ((mem[$past(wr_addr_i)] & ~$past(wr_slot_o)) == '0));

    // R4
    erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> (mem[0] == '1 && mem[DEPTH-1] == '1));
endmodule

// File: rtl/fsp_seq_fsm.sv
// Programming sequencer: detects strobe falling edges, times byte/lock writes,
// and measures the erase hold. Assumes WRITE_CYCLES >= 1 and ERASE_CYCLES >= 2.
module fsp_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int AW           = 6,
    parameter int WRITE_CYCLES = 24,
    parameter int ERASE_CYCLES = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic              prog_en_i,
    input  logic              prog_n_i,
    input  logic              wr_blocked_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic [BYTE_W-1:0] cur_byte_i,
    output logic              busy_o,
    output logic              byte_commit_o,
    output logic              lock_commit_o,
    output logic [1:0]        lock_sel_o,
    output logic              erase_o,
    output logic              poll_o,
    output logic [AW-1:0]     tgt_addr_o,
    output logic [BYTE_W-1:0] tgt_data_o
);
    localparam int MAXC  = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    fs_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic              prog_q;
    logic              is_lock;
    logic              fall, req_ok, wr_last, er_last, commit;
    fs_op_e            op;

    assign op      = fs_op_e'(op_i);
    assign fall    = prog_q && !prog_n_i;
    assign req_ok  = (state == ST_IDLE) && fall && prog_en_i;
    assign wr_last = (cnt == CNT_W'(WRITE_CYCLES - 1));
    assign er_last = (cnt == CNT_W'(ERASE_CYCLES - 1));

    // Sequencer state, counter and captured write target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            prog_q     <= 1'b1;
            is_lock    <= 1'b0;
            lock_sel_o <= '0;
            tgt_addr_o <= '0;
            tgt_data_o <= '1;
        end else begin
            prog_q <= prog_n_i;
            case (state)
                ST_IDLE: begin
                    if (req_ok) begin
                        case (op)
                            OP_BYTE: begin
                                if (!wr_blocked_i) begin
                                    state      <= ST_WR_BUSY;
                                    cnt        <= '0;
                                    is_lock    <= 1'b0;
                                    tgt_addr_o <= addr_i;
                                    tgt_data_o <= cur_byte_i & data_i;
                                end
                            end
                            OP_LK1, OP_LK2, OP_LK3: begin
                                state      <= ST_WR_BUSY;
                                cnt        <= '0;
                                is_lock    <= 1'b1;
                                lock_sel_o <= op_i[1:0];
                            end
                            OP_ERASE: begin
                                state <= ST_ER_HOLD;
                                cnt   <= CNT_W'(1);
                            end
                            default: ;
                        endcase
                    end
                end
                ST_WR_BUSY: begin
                    if (wr_last) state <= ST_IDLE;
                    else         cnt   <= cnt + 1'b1;
                end
                ST_ER_HOLD: begin
                    if (prog_n_i)     state <= ST_IDLE;
                    else if (er_last) state <= ST_ER_WAIT;
                    else              cnt   <= cnt + 1'b1;
                end
                ST_ER_WAIT: begin
                    if (prog_n_i) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign commit        = (state == ST_WR_BUSY) && wr_last;
    assign busy_o        = (state != ST_IDLE);
    assign byte_commit_o = commit && !is_lock;
    assign lock_commit_o = commit && is_lock;
    assign erase_o       = (state == ST_ER_HOLD) && !prog_n_i && er_last;
    assign poll_o        = (state == ST_WR_BUSY) && !is_lock;

    // R2
    wr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ok && op == OP_BYTE && !wr_blocked_i) |=> (busy_o && poll_o));

    // R5
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_BUSY && !wr_last) |=> ($stable(tgt_addr_o) && $stable(tgt_data_o)));

    // R7
    wr_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ok && op == OP_BYTE && wr_blocked_i) |=> !busy_o);
endmodule

// File: rtl/fsp_lock_ctrl.sv
// Lock bits and external-access capture. Lock bits only set through a lock
// commit and only clear through chip erase.
module fsp_lock_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lock_wr_i,
    input  logic [1:0] lock_sel_i,
    input  logic       erase_i,
    input  logic       run_rst_i,
    input  logic       ea_n_i,
    output logic       wr_blocked_o,
    output logic       vfy_blocked_o,
    output logic       ext_fetch_o
);
    logic [2:0] lb;
    logic       ea_lat;
    logic       ea_eff_n;

    // Lock bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_i) begin
            lb <= '0;
        end else if (lock_wr_i) begin
            case (lock_sel_i)
                2'd0:    lb[0] <= 1'b1;
                2'd1:    lb[1] <= 1'b1;
                2'd2:    lb[2] <= 1'b1;
                default: ;
            endcase
        end
    end

    // Capture the external-access strap while device reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n)         ea_lat <= 1'b1;
        else if (run_rst_i) ea_lat <= ea_n_i;
    end

    assign ea_eff_n      = lb[0] ? ea_lat : ea_n_i;
    assign wr_blocked_o  = lb[0];
    assign vfy_blocked_o = lb[0] & lb[1];
    assign ext_fetch_o   = !ea_eff_n && !(&lb);

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_wr_i && !erase_i) |=> $stable(lb));

    // R4
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> (lb == 3'b000));
endmodule

// File: rtl/fsp_read_port.sv
// Registered read path: signature, verify lock gating, data polling, array data.
module fsp_read_port
    import flash_seq_pkg::*;
#(
    parameter int   AW      = 6,
    parameter logic HV_PART = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [1:0]        sig_sel_n_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [BYTE_W-1:0] arr_byte_i,
    input  logic              vfy_blocked_i,
    input  logic              poll_i,
    input  logic [AW-1:0]     tgt_addr_i,
    input  logic [BYTE_W-1:0] tgt_data_i,
    output logic [BYTE_W-1:0] rdata_o
);
    logic              is_read, is_sig;
    logic [BYTE_W-1:0] nxt;

    assign is_read = (fs_op_e'(op_i) == OP_READ);
    assign is_sig  = (sig_sel_n_i == 2'b00);

    // Select the next read byte by priority.
    always_comb begin
        if (!is_read)
            nxt = '0;
        else if (is_sig)
            nxt = sig_byte(32'(addr_i), HV_PART);
        else if (vfy_blocked_i)
            nxt = '0;
        else if (poll_i && addr_i == tgt_addr_i)
            nxt = {~tgt_data_i[BYTE_W-1], tgt_data_i[BYTE_W-2:0]};
        else
            nxt = arr_byte_i;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_o <= '0;
        else        rdata_o <= nxt;
    end

    // R8
    vfy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && !is_sig && vfy_blocked_i) |=> (rdata_o == '0));

    // R6
    sig_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && is_sig && 32'(addr_i) == 32'h31) |=> (rdata_o == 8'h51));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> (rdata_o == '0));
endmodule

// File: rtl/flash_prog_seq.sv
// Top: programming-mode controller for the code array. Connects the sequencer,
// the array, the lock bits and the read port. Inputs are assumed synchronous to clk.
module flash_prog_seq
    import flash_seq_pkg::*;
#(
    parameter int   ARR_AW       = 6,
    parameter int   WRITE_CYCLES = 24,
    parameter int   ERASE_CYCLES = 60,
    parameter logic HV_PART      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [ARR_AW-1:0] addr_i,
    input  logic [7:0]        data_i,
    input  logic [1:0]        sig_sel_n_i,
    input  logic              prog_en_i,
    input  logic              prog_n_i,
    input  logic              run_rst_i,
    input  logic              ea_n_i,
    output logic [7:0]        rdata_o,
    output logic              ready_o,
    output logic              ext_fetch_o
);
    logic              busy, byte_commit, lock_commit, erase, poll;
    logic              wr_blocked, vfy_blocked;
    logic [1:0]        lock_sel;
    logic [ARR_AW-1:0] tgt_addr;
    logic [BYTE_W-1:0] tgt_data, arr_byte, slot_byte;

    fsp_seq_fsm #(
        .AW(ARR_AW), .WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .prog_en_i(prog_en_i),
        .prog_n_i(prog_n_i), .wr_blocked_i(wr_blocked), .addr_i(addr_i),
        .data_i(data_i), .cur_byte_i(arr_byte), .busy_o(busy),
        .byte_commit_o(byte_commit), .lock_commit_o(lock_commit),
        .lock_sel_o(lock_sel), .erase_o(erase), .poll_o(poll),
        .tgt_addr_o(tgt_addr), .tgt_data_o(tgt_data)
    );

    fsp_code_array #(.AW(ARR_AW)) arr_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(byte_commit), .wr_addr_i(tgt_addr),
        .wr_data_i(tgt_data), .erase_i(erase), .rd_addr_i(addr_i),
        .rd_data_o(arr_byte), .wr_slot_o(slot_byte)
    );

    fsp_lock_ctrl lock_i (
        .clk(clk), .rst_n(rst_n), .lock_wr_i(lock_commit), .lock_sel_i(lock_sel),
        .erase_i(erase), .run_rst_i(run_rst_i), .ea_n_i(ea_n_i),
        .wr_blocked_o(wr_blocked), .vfy_blocked_o(vfy_blocked),
        .ext_fetch_o(ext_fetch_o)
    );

    fsp_read_port #(.AW(ARR_AW), .HV_PART(HV_PART)) rd_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .sig_sel_n_i(sig_sel_n_i),
        .addr_i(addr_i), .arr_byte_i(arr_byte), .vfy_blocked_i(vfy_blocked),
        .poll_i(poll), .tgt_addr_i(tgt_addr), .tgt_data_i(tgt_data),
        .rdata_o(rdata_o)
    );

    assign ready_o = !busy;

    // R3
    poll_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_commit |=> (!busy && slot_byte == $past(tgt_data)));
endmodule

// File: tb/flash_prog_seq_tb_top.sv
module flash_prog_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 6;
    localparam int WC  = 24;
    localparam int EC  = 60;
    localparam int DEP = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    op;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    logic [1:0]    sig_n;
    logic          prog_en, prog_n, run_rst, ea_n;
    logic [7:0]    rdata;
    logic          ready, ext_fetch;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    logic [7:0] model [DEP];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prog_seq #(.ARR_AW(AW), .WRITE_CYCLES(WC), .ERASE_CYCLES(EC), .HV_PART(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op), .addr_i(addr), .data_i(data),
        .sig_sel_n_i(sig_n), .prog_en_i(prog_en), .prog_n_i(prog_n),
        .run_rst_i(run_rst), .ea_n_i(ea_n), .rdata_o(rdata), .ready_o(ready),
        .ext_fetch_o(ext_fetch)
    );

    function automatic logic [7:0] sig_exp(input logic [AW-1:0] a);
        case (a)
            6'h30:   return 8'h1E;
            6'h31:   return 8'h51;
            6'h32:   return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] poll_exp(input logic [7:0] t);
        return {~t[7], t[6:0]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        op = 3'd0; prog_n = 1'b1; prog_en = 1'b0; sig_n = 2'b11;
    endtask

    // Read one byte: present the request, sample one negedge later.
    task automatic rd(input logic [AW-1:0] a, input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        op = 3'd2; addr = a; sig_n = s;
        @(negedge clk);
        v = rdata;
        op = 3'd0; sig_n = 2'b11;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, 2'b11, v);
        chk(req, v, exp);
    endtask

    // Strobe an operation; when busy is expected, check the exact busy window.
    task automatic do_op(input string req, input logic [2:0] o, input logic [AW-1:0] a,
                         input logic [7:0] d, input logic en, input bit expect_busy);
        @(negedge clk);
        op = o; addr = a; data = d; prog_en = en; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1; op = 3'd0; prog_en = 1'b0;
        chk(req, {7'd0, ready}, {7'd0, !expect_busy});
        if (expect_busy) begin
            repeat (WC - 1) @(negedge clk);
            chk(req, {7'd0, ready}, 8'd0);
            @(negedge clk);
            chk(req, {7'd0, ready}, 8'd1);
        end
    endtask

    task automatic byte_write(input logic [AW-1:0] a, input logic [7:0] d);
        do_op("R2", 3'd1, a, d, 1'b1, 1'b1);
        model[a] = model[a] & d;
    endtask

    task automatic do_erase(input int hold);
        @(negedge clk);
        op = 3'd3; prog_en = 1'b1; prog_n = 1'b0;
        @(negedge clk);
        chk("R4 busy during hold", {7'd0, ready}, 8'd0);
        repeat (hold - 1) @(negedge clk);
        prog_n = 1'b1; op = 3'd0; prog_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 ready after release", {7'd0, ready}, 8'd1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'hC0DE5EED);
        rst_n = 1'b0; addr = '0; data = '0; run_rst = 1'b0; ea_n = 1'b1;
        idle_inputs();
        for (int i = 0; i < DEP; i++) model[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 ready", {7'd0, ready}, 8'd1);
        rd_chk("R1 blank low", 6'h00, 8'hFF);
        rd_chk("R1 blank high", 6'h3F, 8'hFF);
        chk("R10 ext fetch live strap high", {7'd0, ext_fetch}, 8'd0);

        // R11 no read -> zero, registered one cycle
        @(negedge clk); op = 3'd0;
        @(negedge clk);
        chk("R11 idle rdata", rdata, 8'h00);

        // R2/R3 directed write with polling
        @(negedge clk);
        op = 3'd1; addr = 6'd5; data = 8'hA5; prog_en = 1'b1; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1; prog_en = 1'b0; op = 3'd2; sig_n = 2'b11;
        chk("R2 busy after strobe", {7'd0, ready}, 8'd0);
        @(negedge clk);
        chk("R3 polling bit7 inverted", rdata, poll_exp(8'hA5));
        repeat (WC - 2) @(negedge clk);
        chk("R2 still busy at last cycle", {7'd0, ready}, 8'd0);
        @(negedge clk);
        chk("R2 ready after write", {7'd0, ready}, 8'd1);
        @(negedge clk);
        chk("R3 true data after write", rdata, 8'hA5);
        op = 3'd0;
        model[5] = 8'hA5;

        // R2 AND merge
        byte_write(6'd5, 8'h3C);
        rd_chk("R2 and merge", 6'd5, model[5]);

        // R5 strobe with prog_en low ignored
        do_op("R5 no enable", 3'd1, 6'd7, 8'h00, 1'b0, 1'b0);
        rd_chk("R5 no enable content", 6'd7, 8'hFF);

        // R5 strobe while busy ignored
        @(negedge clk);
        op = 3'd1; addr = 6'd8; data = 8'h0F; prog_en = 1'b1; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1;
        @(negedge clk);
        addr = 6'd9; data = 8'h00; prog_n = 1'b0;
        @(negedge clk);
        prog_n = 1'b1; op = 3'd0; prog_en = 1'b0;
        repeat (WC + 2) @(negedge clk);
        chk("R5 ready after busy strobe", {7'd0, ready}, 8'd1);
        model[8] = 8'h0F;
        rd_chk("R5 first write kept", 6'd8, 8'h0F);
        rd_chk("R5 busy strobe ignored", 6'd9, 8'hFF);

        // R6 signatures
        rd(6'h30, 2'b00, v); chk("R6 sig 30", v, sig_exp(6'h30));
        rd(6'h31, 2'b00, v); chk("R6 sig 31", v, sig_exp(6'h31));
        rd(6'h32, 2'b00, v); chk("R6 sig 32 hv", v, sig_exp(6'h32));
        rd(6'h33, 2'b00, v); chk("R6 sig other", v, sig_exp(6'h33));
        rd(6'h30, 2'b01, v); chk("R6 one pin high reads array", v, model[6'h30]);

        // Random writes and reads against the model (R2)
        for (int k = 0; k < 40; k++) begin
            logic [AW-1:0] ra;
            logic [7:0]    rdv;
            ra  = AW'($urandom_range(0, DEP - 1));
            rdv = 8'($urandom);
            byte_write(ra, rdv);
            rd_chk("R2 random readback", ra, model[ra]);
            ra = AW'($urandom_range(0, DEP - 1));
            rd_chk("R2 random other", ra, model[ra]);
        end

        // R4 aborted erase keeps contents
        do_erase(EC - 2);
        rd_chk("R4 abort keeps", 6'd5, model[5]);
        rd_chk("R4 abort keeps 8", 6'd8, model[8]);

        // R4 full erase
        do_erase(EC + 2);
        for (int i = 0; i < DEP; i++) model[i] = 8'hFF;
        rd_chk("R4 erased 5", 6'd5, 8'hFF);
        rd_chk("R4 erased 8", 6'd8, 8'hFF);
        rd_chk("R4 erased 3F", 6'h3F, 8'hFF);

        // R8 lock bit 2 alone does not block reads
        byte_write(6'd5, 8'h5A);
        do_op("R7 lock2 write", 3'd5, 6'd0, 8'h00, 1'b1, 1'b1);
        rd_chk("R8 lock2 alone reads", 6'd5, 8'h5A);
        do_erase(EC + 2);
        for (int i = 0; i < DEP; i++) model[i] = 8'hFF;
        byte_write(6'd5, 8'h5A);

        // R10 live strap while lock bit 1 clear
        @(negedge clk); ea_n = 1'b0;
        @(negedge clk);
        chk("R10 live strap low", {7'd0, ext_fetch}, 8'd1);
        ea_n = 1'b1;
        @(negedge clk);
        chk("R10 live strap high", {7'd0, ext_fetch}, 8'd0);

        // R7 lock bit 1 refuses writes
        do_op("R7 lock1 write", 3'd4, 6'd0, 8'h00, 1'b1, 1'b1);
        do_op("R7 write refused", 3'd1, 6'd5, 8'h00, 1'b1, 1'b0);
        rd_chk("R7 byte unchanged", 6'd5, 8'h5A);

        // R10 latched strap while lock bit 1 set
        @(negedge clk); ea_n = 1'b0;
        @(negedge clk);
        chk("R10 latched reset value", {7'd0, ext_fetch}, 8'd0);
        run_rst = 1'b1;
        @(negedge clk); run_rst = 1'b0; ea_n = 1'b1;
        @(negedge clk);
        chk("R10 latched low held", {7'd0, ext_fetch}, 8'd1);

        // R8 lock bits 1+2 block reads, signature still readable
        do_op("R7 lock2 after lock1", 3'd5, 6'd0, 8'h00, 1'b1, 1'b1);
        rd_chk("R8 read blocked", 6'd5, 8'h00);
        rd(6'h31, 2'b00, v); chk("R8 sig still read", v, 8'h51);
        chk("R9 two locks ext allowed", {7'd0, ext_fetch}, 8'd1);

        // R9 all three locks block external fetch
        do_op("R7 lock3 write", 3'd6, 6'd0, 8'h00, 1'b1, 1'b1);
        chk("R9 ext blocked", {7'd0, ext_fetch}, 8'd0);

        // R4 erase clears locks
        do_erase(EC + 2);
        rd_chk("R4 locks cleared read", 6'd5, 8'hFF);
        @(negedge clk); ea_n = 1'b0;
        @(negedge clk);
        chk("R4 locks cleared ext live", {7'd0, ext_fetch}, 8'd1);
        byte_write(6'd2, 8'h81);
        rd_chk("R4 writes allowed after erase", 6'd2, 8'h81);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule